// File: doc/BRIEF.md
# Go-Back-N Transmit Window

This block is the sending half of a sliding-window link that recovers from loss by going back. Frames arrive on an upstream valid/ready stream. Each accepted frame is stored and tagged with the next sequence number, counting modulo 2^SEQ_W. Stored frames leave on a downstream valid/ready stream, one per cycle, without waiting for acknowledgements, until the window of WIN outstanding frames is full.

The far end returns cumulative acknowledgements. An acknowledgement naming sequence n releases every outstanding frame up to and including n. One retransmission timer watches the oldest unacknowledged frame. When it runs out, the send pointer moves back to that frame, and everything from there onward is sent again in its original order. Resent frames carry a flag so the link can tell them apart from first transmissions. A status output gives the number of frames held in the window and says when the window is full.

Top module: `gbn_sender`

## Requirements
- R1: While reset is held and right after it, `out_valid` is 0, `win_count` is 0, `in_ready` is 1 and `win_full` is 0.
- R2: An upstream frame is taken only while `win_count` < WIN. Each taken frame raises `win_count` by one at the next edge. `win_full` is 1 exactly when `win_count` equals WIN.
- R3: Frames are numbered in the order they are taken: 0 first after reset, then each one plus one, wrapping modulo 2^SEQ_W. The first transmission of a frame shows its own number on `out_seq`, its stored payload on `out_data`, and `out_retx` = 0.
- R4: While taken-but-unsent frames exist, `out_valid` stays 1, so consecutive frames go out on consecutive cycles when `out_ready` is 1, with no acknowledgement needed in between.
- R5: While `out_valid` is 1 and `out_ready` is 0, with no acknowledgement and no timeout, `out_seq` and `out_data` hold their values.
- R6: An acknowledgement (`ack_valid` = 1, `ack_seq` = n) for a frame that has been sent at least once and is still outstanding releases every frame from the oldest one through n. `win_count` drops by that number at the next edge. This also holds when a frame is sent on the same edge.
- R7: An acknowledgement whose number is not that of a transmitted, still-outstanding frame is ignored. This covers numbers already released, numbers not yet sent, and any number while nothing is outstanding. `win_count` is left unchanged.
- R8: The timer starts at the edge where the first frame is sent into an empty window, and it restarts at every rewind. If no acknowledgement arrives, `timeout_cycles` edges later the send pointer rewinds to the oldest outstanding frame. That frame and every later one are sent again in order with `out_retx` = 1, and then new frames follow with `out_retx` = 0.
- R9: An accepted acknowledgement that leaves transmitted frames outstanding restarts the timer, so the next rewind comes `timeout_cycles` edges after that acknowledgement. When nothing is outstanding, no rewind ever occurs. An acknowledgement and a timer expiry on the same edge resolve in favour of the acknowledgement.
- R10: After a rewind, an acknowledgement that covers frames not yet re-sent moves the send pointer past them, so they are not sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream frame present |
| in_data | input | DATA_W | Upstream frame payload |
| in_ready | output | 1 | Window has room for another frame |
| out_valid | output | 1 | A frame is offered downstream |
| out_data | output | DATA_W | Payload of the offered frame |
| out_seq | output | SEQ_W | Sequence number of the offered frame |
| out_retx | output | 1 | Offered frame is a retransmission |
| out_ready | input | 1 | Downstream takes the offered frame |
| ack_valid | input | 1 | Cumulative acknowledgement present |
| ack_seq | input | SEQ_W | Highest sequence number acknowledged |
| timeout_cycles | input | TIMER_W | Timer length in clock cycles, at least 1 |
| win_count | output | SEQ_W | Frames currently held in the window |
| win_full | output | 1 | Window holds WIN frames |

## Verification
The bench builds the block with SEQ_W = 3, WIN = 5, DATA_W = 8 and TIMER_W = 8. With eight sequence numbers and a window of five, the number wraps from 7 to 0 within a few dozen frames. The same configuration leaves numbers both behind and ahead of the window, so stale acknowledgements and acknowledgements for unsent frames can both be tested. Setting `timeout_cycles` to 6 places every expiry, restart and ack-versus-expiry collision on an edge that can be counted exactly from the stimulus.

// File: rtl/gbn_pkg.sv
package gbn_pkg;

    // What the transmit side offers downstream in the current cycle
    typedef enum logic [1:0] {
        SEND_IDLE = 2'd0,
        SEND_NEW  = 2'd1,
        SEND_RETX = 2'd2
    } send_kind_e;

endpackage

// File: rtl/gbn_frame_store.sv
// Payload storage addressed directly by sequence number.
module gbn_frame_store #(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/gbn_ack_window.sv
// Decides whether a cumulative acknowledgement names a transmitted,
// still-outstanding frame, and how many frames it releases.
module gbn_ack_window #(
    parameter int unsigned SEQ_W = 3
) (
    input  logic             ack_valid,
    input  logic [SEQ_W-1:0] ack_seq,
    input  logic [SEQ_W-1:0] base,
    input  logic [SEQ_W-1:0] sent_span,
    output logic             hit,
    output logic [SEQ_W-1:0] freed
);
    logic [SEQ_W-1:0] ack_off;

    assign ack_off = ack_seq - base;
    assign hit     = ack_valid && (ack_off < sent_span);
    assign freed   = ack_off + SEQ_W'(1);

endmodule

// File: rtl/gbn_retx_timer.sv
// Single retransmission timer for the oldest outstanding frame.
module gbn_retx_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] tick_q, tick_d;

    always_comb begin
        expire = run && !restart && (tick_q == limit - CNT_W'(1));
        if (!run || restart || expire) begin
            tick_d = '0;
        end else begin
            tick_d = tick_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

endmodule

// File: rtl/gbn_sender.sv
module gbn_sender
    import gbn_pkg::*;
#(
    parameter int unsigned SEQ_W   = 3,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned WIN     = (1 << SEQ_W) - 1,
    parameter int unsigned TIMER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic [SEQ_W-1:0]   out_seq,
    output logic               out_retx,
    input  logic               out_ready,
    input  logic               ack_valid,
    input  logic [SEQ_W-1:0]   ack_seq,
    input  logic [TIMER_W-1:0] timeout_cycles,
    output logic [SEQ_W-1:0]   win_count,
    output logic               win_full
);
    localparam logic [SEQ_W-1:0] WIN_L = SEQ_W'(WIN);

    // Four sequence pointers: oldest outstanding, next to send,
    // first never sent, next to assign.
    typedef struct packed {
        logic [SEQ_W-1:0] base;
        logic [SEQ_W-1:0] nxt;
        logic [SEQ_W-1:0] hw;
        logic [SEQ_W-1:0] tail;
    } ptr_t;

    ptr_t             ptr_q, ptr_d;
    logic [SEQ_W-1:0] off_next, off_hw, off_tail;
    logic [SEQ_W-1:0] n_next, n_hw, n_tail;
    logic [SEQ_W-1:0] ack_freed;
    logic [SEQ_W-1:0] base_q;
    logic             ack_hit, tmr_expire, tmr_run;
    logic             fire_in, fire_out;
    send_kind_e       kind;

    // Offsets from the window base never exceed WIN, so they never alias.
    assign off_next = ptr_q.nxt  - ptr_q.base;
    assign off_hw   = ptr_q.hw   - ptr_q.base;
    assign off_tail = ptr_q.tail - ptr_q.base;
    assign base_q   = ptr_q.base;

    always_comb begin
        if (off_next == off_tail) begin
            kind = SEND_IDLE;
        end else if (off_next < off_hw) begin
            kind = SEND_RETX;
        end else begin
            kind = SEND_NEW;
        end
    end

    assign in_ready  = (off_tail < WIN_L);
    assign fire_in   = in_valid && in_ready;
    assign out_valid = (kind != SEND_IDLE);
    assign out_retx  = (kind == SEND_RETX);
    assign out_seq   = ptr_q.nxt;
    assign fire_out  = out_valid && out_ready;
    assign win_count = off_tail;
    assign win_full  = (off_tail == WIN_L);
    assign tmr_run   = (off_hw != '0);

    gbn_frame_store #(
        .IDX_W  (SEQ_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (fire_in),
        .wr_idx  (ptr_q.tail),
        .wr_data (in_data),
        .rd_idx  (ptr_q.nxt),
        .rd_data (out_data)
    );

    gbn_ack_window #(
        .SEQ_W (SEQ_W)
    ) u_ackw (
        .ack_valid (ack_valid),
        .ack_seq   (ack_seq),
        .base      (ptr_q.base),
        .sent_span (off_hw),
        .hit       (ack_hit),
        .freed     (ack_freed)
    );

    gbn_retx_timer #(
        .CNT_W (TIMER_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (ack_hit),
        .limit   (timeout_cycles),
        .expire  (tmr_expire)
    );

    always_comb begin
        // Send progress, or rewind to the base on expiry.
        n_next = tmr_expire ? '0 : off_next + SEQ_W'(fire_out);
        n_hw   = (n_next > off_hw) ? n_next : off_hw;
        n_tail = off_tail + SEQ_W'(fire_in);
        ptr_d.base = ptr_q.base;
        if (ack_hit) begin
            // Released frames leave the window; the send pointer skips them.
            n_next     = (n_next > ack_freed) ? n_next - ack_freed : '0;
            n_hw       = n_hw - ack_freed;
            n_tail     = n_tail - ack_freed;
            ptr_d.base = ptr_q.base + ack_freed;
        end
        ptr_d.nxt  = ptr_d.base + n_next;
        ptr_d.hw   = ptr_d.base + n_hw;
        ptr_d.tail = ptr_d.base + n_tail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/gbn_sender_checker.sv
module gbn_sender_checker #(
    parameter int unsigned SEQ_W  = 3,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WIN    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SEQ_W-1:0]  out_seq,
    input logic [DATA_W-1:0] out_data,
    input logic [SEQ_W-1:0]  win_count,
    input logic              ack_valid,
    input logic              ack_hit,
    input logic              expire,
    input logic [SEQ_W-1:0]  base
);
    p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= SEQ_W'(WIN));

    p_accept_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !ack_hit) |=> win_count == SEQ_W'($past(win_count) + 1'b1));

    p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !expire && !ack_hit)
            |=> (!out_valid || out_seq == SEQ_W'($past(out_seq) + 1'b1)));

    p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !expire && !ack_valid)
            |=> (out_valid && $stable(out_seq) && $stable(out_data)));

    p_stray_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_hit && !(in_valid && in_ready)) |=> $stable(win_count));

    p_rewind_to_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (out_valid && out_seq == $past(base)));

endmodule

bind gbn_sender gbn_sender_checker #(
    .SEQ_W  (SEQ_W),
    .DATA_W (DATA_W),
    .WIN    (WIN)
) u_gbn_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_seq   (out_seq),
    .out_data  (out_data),
    .win_count (win_count),
    .ack_valid (ack_valid),
    .ack_hit   (ack_hit),
    .expire    (tmr_expire),
    .base      (base_q)
);

// File: tb/gbn_sender_bench.sv
module gbn_sender_bench;
    localparam int SEQ_W   = 3;
    localparam int DATA_W  = 8;
    localparam int WIN     = 5;
    localparam int TIMER_W = 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic [DATA_W-1:0]  in_data;
    logic               in_ready;
    logic               out_valid;
    logic [DATA_W-1:0]  out_data;
    logic [SEQ_W-1:0]   out_seq;
    logic               out_retx;
    logic               out_ready;
    logic               ack_valid;
    logic [SEQ_W-1:0]   ack_seq;
    logic [TIMER_W-1:0] timeout_cycles;
    logic [SEQ_W-1:0]   win_count;
    logic               win_full;

    always #2 clk = ~clk;

    gbn_sender #(
        .SEQ_W   (SEQ_W),
        .DATA_W  (DATA_W),
        .WIN     (WIN),
        .TIMER_W (TIMER_W)
    ) u_gbn_sender (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .out_data       (out_data),
        .out_seq        (out_seq),
        .out_retx       (out_retx),
        .out_ready      (out_ready),
        .ack_valid      (ack_valid),
        .ack_seq        (ack_seq),
        .timeout_cycles (timeout_cycles),
        .win_count      (win_count),
        .win_full       (win_full)
    );

    int checks = 0;
    int errors = 0;
    int pushed = 0;
    logic [SEQ_W-1:0]  tseq = '0;
    logic [DATA_W-1:0] exp_data [1 << SEQ_W];

    function automatic logic [DATA_W-1:0] pat(input int k);
        return DATA_W'(k * 37 + 11);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Offer one frame for one cycle; record it if it is taken.
    task automatic push_one(output bit taken);
        in_valid = 1'b1;
        in_data  = pat(pushed);
        taken    = in_ready;
        if (taken) begin
            exp_data[tseq] = pat(pushed);
            tseq   = tseq + 1'b1;
            pushed++;
        end
        step();
        in_valid = 1'b0;
    endtask

    task automatic send_ack(input int n);
        ack_valid = 1'b1;
        ack_seq   = SEQ_W'(n);
        step();
        ack_valid = 1'b0;
    endtask

    task automatic check_offer(input string tag, input int seq, input bit retx);
        check(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
        check(int'(out_seq) == seq, {tag, " seq"}, int'(out_seq), seq);
        check(out_data == exp_data[seq], {tag, " data"}, int'(out_data), int'(exp_data[seq]));
        check(out_retx == retx, {tag, " retx"}, int'(out_retx), int'(retx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit taken;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_data = '0;
        out_ready = 1'b0;
        ack_valid = 1'b0;
        ack_seq = '0;
        timeout_cycles = TIMER_W'(40);
        repeat (3) @(negedge clk);

        // R1 reset values
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(win_count == '0, "R1 win_count in reset", int'(win_count), 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        step();
        check(win_count == '0 && !out_valid && !win_full, "R1 after release", int'(win_count), 0);

        // R2 fill with downstream stalled; R5 hold the offer
        for (int i = 0; i < 7; i++) begin
            check(in_ready == (i < WIN), "R2 in_ready while filling", int'(in_ready), int'(i < WIN));
            push_one(taken);
        end
        check(int'(win_count) == WIN, "R2 count at full", int'(win_count), WIN);
        check(win_full == 1'b1, "R2 win_full", int'(win_full), 1);
        check_offer("R5 stalled offer", 0, 1'b0);
        step();
        step();
        check_offer("R5 held offer", 0, 1'b0);

        // R3 R4 back-to-back first transmissions
        out_ready = 1'b1;
        for (int i = 0; i < WIN; i++) begin
            check_offer("R4 streaming", i, 1'b0);
            step();
        end
        check(out_valid == 1'b0, "R4 all sent", int'(out_valid), 0);
        check(int'(win_count) == WIN, "R4 none released yet", int'(win_count), WIN);

        // R6 cumulative ack, R7 stray acks
        send_ack(2);
        check(int'(win_count) == 2, "R6 ack 2 releases three", int'(win_count), 2);
        check(win_full == 1'b0 && in_ready, "R6 room again", int'(win_full), 0);
        send_ack(1);
        check(int'(win_count) == 2, "R7 stale ack ignored", int'(win_count), 2);
        send_ack(6);
        check(int'(win_count) == 2, "R7 unsent ack ignored", int'(win_count), 2);
        send_ack(4);
        check(int'(win_count) == 0, "R6 ack 4 empties window", int'(win_count), 0);
        check(out_valid == 1'b0, "R6 nothing to send", int'(out_valid), 0);

        // R8 timeout rewind
        timeout_cycles = TIMER_W'(6);
        out_ready = 1'b0;
        for (int i = 0; i < 3; i++) push_one(taken);
        check(int'(win_count) == 3, "R8 three queued", int'(win_count), 3);
        out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            check_offer("R8 first send", 5 + i, 1'b0);
            step();
        end
        check(out_valid == 1'b0, "R8 idle after sends", int'(out_valid), 0);
        step();
        step();
        step();
        check(out_valid == 1'b0, "R8 no rewind before limit", int'(out_valid), 0);
        step();
        for (int i = 0; i < 3; i++) begin
            check_offer("R8 resend", (5 + i) % 8, 1'b1);
            step();
        end
        check(out_valid == 1'b0, "R8 resend done", int'(out_valid), 0);
        push_one(taken);
        check_offer("R3 wrapped new frame", 0, 1'b0);
        ack_valid = 1'b1;
        ack_seq = 3'd7;
        step();
        check(int'(win_count) == 1, "R6 ack with concurrent send", int'(win_count), 1);
        check(out_valid == 1'b0, "R6 frame 0 sent", int'(out_valid), 0);
        ack_seq = 3'd0;
        step();
        ack_valid = 1'b0;
        check(int'(win_count) == 0, "R9 ack beats expiry", int'(win_count), 0);
        repeat (10) step();
        check(out_valid == 1'b0 && win_count == '0, "R9 no rewind when empty", int'(out_valid), 0);

        // R9 restart on partial ack
        out_ready = 1'b0;
        push_one(taken);
        push_one(taken);
        out_ready = 1'b1;
        check_offer("R9 send 1", 1, 1'b0);
        step();
        check_offer("R9 send 2", 2, 1'b0);
        step();
        step();
        step();
        send_ack(1);
        check(int'(win_count) == 1, "R6 partial ack", int'(win_count), 1);
        step();
        step();
        check(out_valid == 1'b0, "R9 old deadline passes", int'(out_valid), 0);
        step();
        step();
        step();
        check(out_valid == 1'b0, "R9 no early rewind", int'(out_valid), 0);
        step();
        check_offer("R9 rewind after restart", 2, 1'b1);
        out_ready = 1'b0;

        // R10 ack covers the frame waiting for resend
        send_ack(2);
        check(int'(win_count) == 0, "R10 ack during rewind", int'(win_count), 0);
        check(out_valid == 1'b0, "R10 acked frame not resent", int'(out_valid), 0);
        push_one(taken);
        check_offer("R10 resumes with new frame", 3, 1'b0);
        out_ready = 1'b1;
        step();
        send_ack(3);
        check(int'(win_count) == 0, "R6 final release", int'(win_count), 0);
        send_ack(3);
        check(int'(win_count) == 0, "R7 ack with empty window", int'(win_count), 0);
        check(in_ready == 1'b1 && !win_full, "R2 ready when empty", int'(in_ready), 1);

        finish_run();
    end

endmodule